// File: doc/BRIEF.md
# Erasable Programmable Byte Memory Core

This block is a synthesizable behavioural model of a byte-wide memory that software can only burn once per erase cycle. Each location starts out blank, meaning every bit is one. A program pulse can clear chosen bits to zero. The only way to bring bits back to one is the erase input, which restores the whole array at once. The depth is set by a parameter.

The block samples three active-low controls on every clock: a select line, an output gate and a burn strobe. It also samples two flags. One says the programming supply is raised; the other says the high identification voltage is present on address bit 9. From these five inputs it decodes one of eight operating modes.

The data bus is modelled as a driven value plus a drive-enable flag. A surrounding tri-state buffer can use the two to recreate the shared bus. Outputs are registered, so the value seen on a clock edge reflects the inputs sampled one edge earlier.

A burn is tracked by a two-state sequencer:
- `PS_IDLE`: no burn is pending. It moves to `PS_PULSE` when the decoded mode is program.
- `PS_PULSE`: a burn is pending. It stays here while the mode is still program.
  - Commit transition: it returns to `PS_IDLE` and writes when the strobe rises with programming conditions still in place.
  - Abort transition: it returns to `PS_IDLE` without writing on any other input.

Top module: `eprom_core`

## Requirements
- R1: After reset every location reads 8'hFF, `data_oe` is 0 and `mode` is 2 (standby).
- R2: With select low, gate low, strobe high, supply flag low and identification flag low, `mode` is 0 (read). One clock later `data_oe` is 1 and `data_out` holds the addressed byte.
- R3: With select high, `data_oe` is 0 whatever the other inputs are, and no write takes place. `mode` is 5 (inhibit) when the supply flag is high and 2 (standby) when it is low.
- R4: With select low, gate high and strobe high, `data_oe` is 0 and `mode` is 1 (output disable).
- R5: Program (mode 3) needs select low, gate high, strobe low and the supply flag high. When the strobe returns high with select low, gate high and the supply flag high, the stored byte becomes old AND data. A bit therefore never goes from 0 to 1, and repeating a pulse changes nothing.
- R6: With select low, gate low, strobe high and the supply flag high, `mode` is 4 (verify) and the stored byte is driven.
- R7: If a pending burn ends in any way other than the commit condition of R5, nothing is written. Examples are select rising, the supply flag falling or the gate falling.
- R8: With the identification flag high, the supply flag low, select low, gate low and strobe high, `mode` is 6 (signature). The block drives 8'h20 when `addr[0]` is 0 and 8'h61 when it is 1.
- R9: Strobe low together with gate low, or strobe low without the supply flag, gives `mode` 7 (illegal). `data_oe` is then 0 and nothing is written.
- R10: A cycle with `erase` high sets every location to all ones and cancels any pending burn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, returns the array to blank |
| ce_n | input | 1 | Active-low device select |
| oe_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low burn strobe |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hi | input | 1 | Identification voltage on address bit 9 |
| erase | input | 1 | Synchronous erase of the whole array |
| addr | input | ADDR_W | Byte address |
| data_in | input | DATA_W | Byte to burn |
| data_out | output | DATA_W | Driven byte, zero while not driving |
| data_oe | output | 1 | Bus drive enable |
| mode | output | 3 | Decoded operating mode |

## Verification
The bench goes after a burn whose data holds ones over existing zeros. A design that copied the data instead of ANDing it would bring erased-looking bits back. It also ends pulses through a select rise and pulses that start without the raised supply. A design that wrote on any strobe edge would corrupt those addresses. Both signature bytes are read, and so is a burn attempted with select high and the supply raised. Swapped identification codes or a leaky inhibit would show up there as wrong bytes. Finally, erase is raised in the middle of a pending burn. A design that let the commit win would leave a programmed byte after the erase.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    typedef enum logic [2:0] {
        MD_READ      = 3'd0,
        MD_DISABLE   = 3'd1,
        MD_STANDBY   = 3'd2,
        MD_PROGRAM   = 3'd3,
        MD_VERIFY    = 3'd4,
        MD_INHIBIT   = 3'd5,
        MD_SIGNATURE = 3'd6,
        MD_ILLEGAL   = 3'd7
    } op_mode_e;

    typedef enum logic {
        PS_IDLE  = 1'b0,
        PS_PULSE = 1'b1
    } pulse_st_e;

    localparam logic [7:0] ID_MAKER = 8'h20;
    localparam logic [7:0] ID_PART  = 8'h61;

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic     ce_n,
    input  logic     oe_n,
    input  logic     pgm_n,
    input  logic     vpp_hi,
    input  logic     a9_hi,
    output op_mode_e mode
);

    always_comb begin
        if (ce_n) begin
            mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
        end else if (vpp_hi) begin
            unique case ({oe_n, pgm_n})
                2'b10:   mode = MD_PROGRAM;
                2'b01:   mode = MD_VERIFY;
                2'b11:   mode = MD_DISABLE;
                default: mode = MD_ILLEGAL;
            endcase
        end else begin
            unique case ({oe_n, pgm_n})
                2'b01:   mode = a9_hi ? MD_SIGNATURE : MD_READ;
                2'b11:   mode = MD_DISABLE;
                default: mode = MD_ILLEGAL;
            endcase
        end
    end

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_mode_e          mode,
    input  logic              vpp_hi,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    pulse_st_e state_q, state_d;
    logic      commit;

    // Strobe back high while the part is still selected with raised supply
    // and the gate closed: the decoder reports that as disable with vpp_hi.
    always_comb begin
        commit = (state_q == PS_PULSE) && !erase &&
                 (mode == MD_DISABLE) && vpp_hi;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:  if (!erase && mode == MD_PROGRAM) state_d = PS_PULSE;
            PS_PULSE: if (erase || mode != MD_PROGRAM)  state_d = PS_IDLE;
            default:  state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '1;
        end else if (mode == MD_PROGRAM) begin
            wr_addr <= addr;
            wr_data <= data_in;
        end
    end

    always_comb wr_en = commit;

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cells[w] <= '1;
            else if (erase)
                cells[w] <= '1;
            else if (wr_en && wr_addr == ADDR_W'(w))
                cells[w] <= cells[w] & wr_data;
        end
    end

    always_comb rd_data = cells[rd_addr];

endmodule

// File: rtl/eprom_core.sv
module eprom_core
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              a9_hi,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic [2:0]        mode
);

    op_mode_e          cur_mode;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] out_d;
    logic              oe_d;
    op_mode_e          mode_q;

    eprom_mode_dec u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_hi (vpp_hi),
        .a9_hi  (a9_hi),
        .mode   (cur_mode)
    );

    eprom_prog_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (cur_mode),
        .vpp_hi  (vpp_hi),
        .erase   (erase),
        .addr    (addr),
        .data_in (data_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    eprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

    always_comb begin
        out_d = '0;
        oe_d  = 1'b0;
        unique case (cur_mode)
            MD_READ, MD_VERIFY: begin
                out_d = rd_data;
                oe_d  = 1'b1;
            end
            MD_SIGNATURE: begin
                out_d = addr[0] ? DATA_W'(ID_PART) : DATA_W'(ID_MAKER);
                oe_d  = 1'b1;
            end
            MD_DISABLE, MD_STANDBY, MD_PROGRAM,
            MD_INHIBIT, MD_ILLEGAL: begin
                out_d = '0;
                oe_d  = 1'b0;
            end
            default: begin
                out_d = '0;
                oe_d  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out <= '0;
            data_oe  <= 1'b0;
            mode_q   <= MD_STANDBY;
        end else begin
            data_out <= out_d;
            data_oe  <= oe_d;
            mode_q   <= cur_mode;
        end
    end

    always_comb mode = mode_q;

endmodule

// File: rtl/eprom_core_chk.sv
module eprom_core_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              pgm_n,
    input logic              vpp_hi,
    input logic              a9_hi,
    input logic              erase,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data_in,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe,
    input logic [2:0]        mode
);

    assert_standby_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !data_oe);

    assert_inhibit_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && vpp_hi) |=> (mode == 3'd5));

    assert_gate_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !data_oe);

    assert_sig_maker_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && pgm_n && !vpp_hi && a9_hi && !addr[0])
        |=> (data_oe && data_out == DATA_W'(8'h20)));

    assert_sig_part_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && pgm_n && !vpp_hi && a9_hi && addr[0])
        |=> (data_oe && data_out == DATA_W'(8'h61)));

    assert_illegal_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !pgm_n && !oe_n) |=> (!data_oe && mode == 3'd7));

endmodule

bind eprom_core eprom_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_eprom_core.sv
`timescale 1ns/1ps
module test_eprom_core;

    localparam int AW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
    logic          vpp_hi = 1'b0, a9_hi = 1'b0, erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] data_out;
    logic          data_oe;
    logic [2:0]    mode;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    eprom_core #(.ADDR_W(AW), .DATA_W(DW)) i_eprom_core (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .vpp_hi(vpp_hi), .a9_hi(a9_hi), .erase(erase), .addr(addr),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .mode(mode)
    );

    // ---------------- reference model ----------------
    logic [7:0] store [int];
    int         pend_addr = -1;
    logic [7:0] pend_data;
    int         exp_mode;
    logic       exp_oe;
    logic [7:0] exp_out;

    function automatic logic [7:0] peek(int a);
        return store.exists(a) ? store[a] : 8'hFF;
    endfunction

    function automatic string tag_of(int m);
        case (m)
            0: return "R2";
            1: return "R4";
            2, 5: return "R3";
            3: return "R5";
            4: return "R6";
            6: return "R8";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk) begin
        int m;
        if (!rst_n) begin
            store.delete();
            pend_addr = -1;
            exp_mode = 2; exp_oe = 0; exp_out = 0;
        end else begin
            if (ce_n)                    m = vpp_hi ? 5 : 2;
            else if (vpp_hi) begin
                if (oe_n && !pgm_n)      m = 3;
                else if (!oe_n && pgm_n) m = 4;
                else if (oe_n && pgm_n)  m = 1;
                else                     m = 7;
            end
            else if (!pgm_n)             m = 7;
            else if (oe_n)               m = 1;
            else                         m = a9_hi ? 6 : 0;
            exp_mode = m;
            exp_oe   = (m == 0 || m == 4 || m == 6);
            exp_out  = (m == 6) ? (addr[0] ? 8'h61 : 8'h20)
                     : exp_oe ? peek(int'(addr)) : 8'h00;
            if (erase) begin
                store.delete();
                pend_addr = -1;
            end else if (m == 3) begin
                pend_addr = int'(addr);
                pend_data = data_in;
            end else begin
                if (pend_addr >= 0 && m == 1 && vpp_hi)
                    store[pend_addr] = peek(pend_addr) & pend_data;
                pend_addr = -1;
            end
        end
        #1;
        checks++;
        if (int'(mode) != exp_mode || data_oe !== exp_oe ||
            (exp_oe && data_out !== exp_out)) begin
            errors++;
            $display("FAIL %s model: mode=%0d oe=%0b out=%h expected mode=%0d oe=%0b out=%h",
                     tag_of(exp_mode), mode, data_oe, data_out, exp_mode, exp_oe, exp_out);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic apply(input logic c, input logic o, input logic p, input logic v,
                         input logic a9, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic e);
        @(negedge clk);
        ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; a9_hi = a9;
        addr = a; data_in = d; erase = e;
    endtask

    task automatic settle();
        @(posedge clk); #1.5;
    endtask

    task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    task automatic burn(input logic [AW-1:0] a, input logic [DW-1:0] d);
        apply(0, 1, 1, 1, 0, a, d, 0);
        apply(0, 1, 0, 1, 0, a, d, 0);
        apply(0, 1, 0, 1, 0, a, d, 0);
        apply(0, 1, 1, 1, 0, a, d, 0);
    endtask

    task automatic look(input string tag, input logic v, input logic [AW-1:0] a,
                        input logic [DW-1:0] want);
        apply(0, 0, 1, v, 0, a, 8'h00, 0);
        settle();
        chk(tag, {data_oe, data_out}, {1'b1, want});
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1.5;
        chk("R1 reset", {data_oe, 3'b000, 2'b00, mode, 1'b0}, {1'b0, 5'b0, 3'd2, 1'b0});
        @(negedge clk); rst_n = 1'b1;

        look("R1 blank", 0, 8'd3, 8'hFF);
        look("R2 read blank top", 0, 8'hFF, 8'hFF);

        apply(1, 0, 1, 0, 0, 8'd3, 8'h00, 0); settle();
        chk("R3 standby", {data_oe, 5'b0, mode}, {1'b0, 5'b0, 3'd2});

        apply(0, 1, 1, 0, 0, 8'd3, 8'h00, 0); settle();
        chk("R4 disable", {data_oe, 5'b0, mode}, {1'b0, 5'b0, 3'd1});

        burn(8'd5, 8'hA5);
        look("R6 verify", 1, 8'd5, 8'hA5);
        apply(0, 0, 1, 1, 0, 8'd5, 0, 0); settle();
        chk("R6 mode", {6'b0, mode}, {6'b0, 3'd4});
        look("R2 read", 0, 8'd5, 8'hA5);

        burn(8'd5, 8'h0F);
        look("R5 and", 1, 8'd5, 8'h05);
        burn(8'd5, 8'hFF);
        look("R5 no set", 0, 8'd5, 8'h05);
        burn(8'd5, 8'h0F);
        look("R5 repeat", 0, 8'd5, 8'h05);

        apply(1, 1, 0, 1, 0, 8'd5, 8'h00, 0); settle();
        chk("R3 inhibit", {data_oe, 5'b0, mode}, {1'b0, 5'b0, 3'd5});
        apply(1, 1, 1, 1, 0, 8'd5, 8'h00, 0);
        look("R3 inhibit no write", 0, 8'd5, 8'h05);

        apply(0, 1, 0, 1, 0, 8'd6, 8'h00, 0);
        apply(1, 1, 0, 1, 0, 8'd6, 8'h00, 0);
        apply(0, 1, 1, 1, 0, 8'd6, 8'h00, 0);
        look("R7 abort select", 0, 8'd6, 8'hFF);

        apply(0, 1, 0, 1, 0, 8'd8, 8'h00, 0);
        apply(0, 1, 0, 0, 0, 8'd8, 8'h00, 0);
        apply(0, 1, 1, 1, 0, 8'd8, 8'h00, 0);
        look("R7 abort supply", 0, 8'd8, 8'hFF);

        apply(0, 1, 0, 0, 0, 8'd7, 8'h00, 0); settle();
        chk("R9 illegal", {data_oe, 5'b0, mode}, {1'b0, 5'b0, 3'd7});
        apply(0, 1, 1, 0, 0, 8'd7, 8'h00, 0);
        look("R9 no write", 0, 8'd7, 8'hFF);

        apply(0, 0, 1, 0, 1, 8'd0, 8'h00, 0); settle();
        chk("R8 maker", {data_oe, data_out}, {1'b1, 8'h20});
        apply(0, 0, 1, 0, 1, 8'd1, 8'h00, 0); settle();
        chk("R8 part", {data_oe, data_out}, {1'b1, 8'h61});
        chk("R8 mode", {6'b0, mode}, {6'b0, 3'd6});

        apply(1, 1, 1, 0, 0, 8'd0, 8'h00, 1);
        apply(1, 1, 1, 0, 0, 8'd0, 8'h00, 0);
        look("R10 erase", 0, 8'd5, 8'hFF);

        apply(0, 1, 0, 1, 0, 8'd9, 8'h00, 0);
        apply(0, 1, 0, 1, 0, 8'd9, 8'h00, 1);
        apply(0, 1, 1, 1, 0, 8'd9, 8'h00, 0);
        look("R10 erase cancels burn", 0, 8'd9, 8'hFF);

        repeat (2) @(posedge clk);
        #1.5;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule